// File: doc/BRIEF.md
# Integer ALU with Immediate Second Operand

This block is the integer execute unit of a 32-bit pipeline. Each cycle it takes a 6-bit function code, a first source value, a second source value from the register file, and a 13-bit immediate field with a select bit. From these it builds the second operand and computes one result. The operations are add and subtract (each with an optional carry-in form), six bitwise logic operations, and three shifts. The result is purely combinational, so it can be written back in the same cycle.

The unit also holds a 4-bit condition-code register with the flags negative, zero, overflow and carry. Only the function codes that set condition codes update it, and the update takes place on the rising clock edge. The carry-in forms read the carry flag as it stands before that edge. A chain of carry-in operations therefore propagates a multi-word carry or borrow from one cycle to the next.

Top module: `int_alu_imm`

## Requirements
- R1: When `imm_sel_i` is 1, the second operand is `imm13_i` sign-extended to 32 bits. When it is 0, the second operand is `src_b_i`.
- R2: Code 0x00 returns first plus second operand, and code 0x04 returns first minus second. Code 0x08 also adds the current carry flag, and code 0x0C also subtracts it. All results are modulo 2^32.
- R3: The logic codes combine the first operand with the second, or with the bitwise complement of the second. The codes are 0x01 AND, 0x02 OR, 0x03 XOR, 0x05 AND with complement, 0x06 OR with complement and 0x07 XOR with complement.
- R4: Code 0x25 shifts left and code 0x26 shifts right, both filling with zeros. Code 0x27 shifts right and fills with copies of bit 31. The shift amount is bits 4:0 of the second operand, and the higher bits are ignored.
- R5: Each of the codes in R2 and R3 with 0x10 added gives the same result and also loads the flag register at the clock edge. `icc_o` bit 3 is N, which is result bit 31. Bit 2 is Z, which is 1 when the result is zero.
- R6: For the flag-setting add codes, `icc_o` bit 1 (V) is the signed overflow and bit 0 (C) is the carry out of bit 31. For the flag-setting subtract codes, V is the signed overflow and C is 1 when a borrow occurs.
- R7: The flag-setting logic codes clear V and C.
- R8: The shift codes and the codes in R2 and R3 leave `icc_o` unchanged. Any other code gives a result of 0 and also leaves `icc_o` unchanged.
- R9: While `rst_n` is low, `icc_o` is cleared to 0 at each rising clock edge.
- R10: `result_o` follows the inputs in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset |
| func_i | input | 6 | Function code |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Register second operand |
| imm_sel_i | input | 1 | Selects the immediate as second operand |
| imm13_i | input | 13 | Signed immediate field |
| result_o | output | 32 | Combinational result |
| icc_o | output | 4 | Flags {N, Z, V, C} |

## Verification
In the same cycle, a carry-in operation both reads the carry flag and writes a new flag set. To provoke this, the bench runs a flag-setting add that leaves C at 1 and then, directly after it, a flag-setting add or subtract with carry-in. The bench judges the combinational result before the edge against the old carry, and it judges the flags after the edge against the new result alone. A shift placed straight after an overflow checks that the flags hold.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN  = 32;
    localparam int IMM_W = 13;
    localparam int FN_W  = 6;

    typedef logic [FN_W-1:0] fcode_t;

    localparam fcode_t FN_SLL = 6'h25;
    localparam fcode_t FN_SRL = 6'h26;
    localparam fcode_t FN_SRA = 6'h27;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // base code (low 4 bits) names a valid arithmetic or logic operation
    function automatic logic base_ok(input logic [3:0] base);
        return (base[3] == 1'b0) || (base[1:0] == 2'b00);
    endfunction

    function automatic logic is_alu_code(input fcode_t f);
        return (f[5] == 1'b0) && base_ok(f[3:0]);
    endfunction

    function automatic logic sets_flags(input fcode_t f);
        return (f[5:4] == 2'b01) && base_ok(f[3:0]);
    endfunction

    function automatic logic is_shift(input fcode_t f);
        return (f == FN_SLL) || (f == FN_SRL) || (f == FN_SRA);
    endfunction

endpackage

// File: rtl/opnd_sel.sv
module opnd_sel #(
    parameter int W     = 32,
    parameter int IMM_W = 13
) (
    input  logic             imm_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     reg_val,
    output logic [W-1:0]     opnd
);
    localparam int EXT_W = W - IMM_W;

    always_comb begin
        if (imm_sel) opnd = {{EXT_W{imm[IMM_W-1]}}, imm};
        else         opnd = reg_val;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  fcode_t       func,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] result,
    output flags_t       flags,
    output logic         flag_en
);
    localparam int SH_W = $clog2(W);

    logic [3:0]   base;
    logic         is_sub, use_carry, carry_bit, is_arith;
    logic [W-1:0] b_arith, b_logic, r_logic, r_shift;
    logic [W:0]   sum;
    logic [SH_W-1:0] amt;

    always_comb begin
        base      = func[3:0];
        is_arith  = (base[1:0] == 2'b00);
        is_sub    = base[2];
        use_carry = base[3];
        carry_bit = use_carry & c_in;
        b_arith   = is_sub ? ~b : b;
        sum       = {1'b0, a} + {1'b0, b_arith} + {{W{1'b0}}, carry_bit ^ is_sub};

        b_logic = base[2] ? ~b : b;
        case (base[1:0])
            2'b01:   r_logic = a & b_logic;
            2'b10:   r_logic = a | b_logic;
            default: r_logic = a ^ b_logic;
        endcase

        amt = b[SH_W-1:0];
        case (func)
            FN_SLL:  r_shift = a << amt;
            FN_SRL:  r_shift = a >> amt;
            default: r_shift = W'($signed(a) >>> amt);
        endcase

        if (is_alu_code(func))   result = is_arith ? sum[W-1:0] : r_logic;
        else if (is_shift(func)) result = r_shift;
        else                     result = '0;

        flags.n = result[W-1];
        flags.z = (result == '0);
        if (is_arith) begin
            flags.v = (a[W-1] == b_arith[W-1]) && (sum[W-1] != a[W-1]);
            flags.c = sum[W] ^ is_sub;
        end else begin
            flags.v = 1'b0;
            flags.c = 1'b0;
        end
        flag_en = sets_flags(func);
    end
endmodule

// File: rtl/int_alu_imm.sv
module int_alu_imm
    import alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FN_W-1:0]  func_i,
    input  logic [XLEN-1:0]  src_a_i,
    input  logic [XLEN-1:0]  src_b_i,
    input  logic             imm_sel_i,
    input  logic [IMM_W-1:0] imm13_i,
    output logic [XLEN-1:0]  result_o,
    output logic [3:0]       icc_o
);
    typedef struct packed {
        flags_t icc;
    } state_t;

    state_t        st_d, st_q;
    logic [XLEN-1:0] opnd_b;
    flags_t        new_flags;
    logic          flag_en;

    opnd_sel #(.W(XLEN), .IMM_W(IMM_W)) u_sel (
        .imm_sel (imm_sel_i),
        .imm     (imm13_i),
        .reg_val (src_b_i),
        .opnd    (opnd_b)
    );

    alu_core #(.W(XLEN)) u_core (
        .func    (func_i),
        .a       (src_a_i),
        .b       (opnd_b),
        .c_in    (st_q.icc.c),
        .result  (result_o),
        .flags   (new_flags),
        .flag_en (flag_en)
    );

    always_comb begin
        st_d = st_q;
        if (flag_en) st_d.icc = new_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign icc_o = st_q.icc;
endmodule

// File: rtl/int_alu_imm_chk.sv
module int_alu_imm_chk
    import alu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [FN_W-1:0]  func_i,
    input logic [XLEN-1:0]  src_a_i,
    input logic             imm_sel_i,
    input logic [IMM_W-1:0] imm13_i,
    input logic [XLEN-1:0]  result_o,
    input logic [3:0]       icc_o
);
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sets_flags(func_i) |=> $stable(icc_o)); // R8

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_alu_code(func_i) && !is_shift(func_i)) |-> (result_o == '0)); // R8

    AST_N_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sets_flags(func_i) |=> (icc_o[3] == $past(result_o[XLEN-1]))); // R5

    AST_Z_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sets_flags(func_i) |=> (icc_o[2] == ($past(result_o) == '0))); // R5

    AST_LOGIC_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sets_flags(func_i) && func_i[1:0] != 2'b00) |=> (icc_o[1:0] == 2'b00)); // R7

    AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 6'h02 && imm_sel_i && src_a_i == '0)
        |-> (result_o == XLEN'($signed(imm13_i)))); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (icc_o == 4'b0000)); // R9
endmodule

bind int_alu_imm int_alu_imm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_i    (func_i),
    .src_a_i   (src_a_i),
    .imm_sel_i (imm_sel_i),
    .imm13_i   (imm13_i),
    .result_o  (result_o),
    .icc_o     (icc_o)
);

// File: tb/int_alu_imm_test.sv
module int_alu_imm_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  func_i;
    logic [31:0] src_a_i, src_b_i;
    logic        imm_sel_i;
    logic [12:0] imm13_i;
    logic [31:0] result_o;
    logic [3:0]  icc_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    int_alu_imm uut (
        .clk(clk), .rst_n(rst_n), .func_i(func_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .imm_sel_i(imm_sel_i), .imm13_i(imm13_i),
        .result_o(result_o), .icc_o(icc_o)
    );

    typedef struct packed {
        logic [5:0]  f;
        logic [31:0] a;
        logic [31:0] b;
        logic        isel;
        logic [12:0] imm;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 32'd5,        32'd7,        1'b0, 13'h0000, 32'd12},        // R2 add
        '{6'h00, 32'd100,      32'hDEAD,     1'b1, 13'h1FFF, 32'd99},        // R1 imm -1
        '{6'h04, 32'd10,       32'd3,        1'b0, 13'h0000, 32'd7},         // R2 sub
        '{6'h04, 32'd0,        32'd0,        1'b1, 13'h1000, 32'h0000_1000}, // R1 imm -4096
        '{6'h01, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'hF000F000},  // R3 and
        '{6'h05, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'h00F000F0},  // R3 andn
        '{6'h02, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'hFFF0FFF0},  // R3 or
        '{6'h06, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'hF0FFF0FF},  // R3 orn
        '{6'h03, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'h0FF00FF0},  // R3 xor
        '{6'h07, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0000, 32'hF00FF00F},  // R3 xnor
        '{6'h25, 32'h00000001, 32'h00000024, 1'b0, 13'h0000, 32'h00000010},  // R4 sll, high bits ignored
        '{6'h26, 32'h80000000, 32'd0,        1'b1, 13'h001F, 32'h00000001},  // R4 srl by 31
        '{6'h27, 32'h80000000, 32'd4,        1'b0, 13'h0000, 32'hF8000000},  // R4 sra
        '{6'h25, 32'h12345678, 32'd0,        1'b0, 13'h0000, 32'h12345678},  // R4 shift by 0
        '{6'h3F, 32'd1,        32'd1,        1'b0, 13'h0000, 32'd0}          // R8 unknown code
    };

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on negedge, check result before the edge, flags after it
    task automatic step(input string req, input logic [5:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic isel, input logic [12:0] imm,
                        input logic [31:0] exp_res, input logic [3:0] exp_icc);
        @(negedge clk);
        func_i = f; src_a_i = a; src_b_i = b; imm_sel_i = isel; imm13_i = imm;
        #1;
        chk32({req, " result"}, result_o, exp_res);
        @(posedge clk);
        @(negedge clk);
        chk32({req, " flags"}, {28'd0, icc_o}, {28'd0, exp_icc});
        func_i = 6'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; func_i = 6'h00; src_a_i = '0; src_b_i = '0;
        imm_sel_i = 1'b0; imm13_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk32("R9 reset flags", {28'd0, icc_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step("R1-vector", VECS[i].f, VECS[i].a, VECS[i].b, VECS[i].isel,
                 VECS[i].imm, VECS[i].exp, 4'b0000); // R2 R3 R4 R8 R10: flags stay 0
        end

        // R5 R6: overflow into negative
        step("R6 addcc overflow", 6'h10, 32'h7FFFFFFF, 32'd1, 1'b0, 13'h0, 32'h80000000, 4'b1010);
        // R8: shift leaves flags alone
        step("R8 shift holds", 6'h27, 32'h80000000, 32'd1, 1'b0, 13'h0, 32'hC0000000, 4'b1010);
        // R5 R6: carry out and zero
        step("R6 addcc carry", 6'h10, 32'hFFFFFFFF, 32'd1, 1'b0, 13'h0, 32'h0, 4'b0101);
        // R2: carry-in consumed while flags rewritten in same cycle
        step("R2 addxcc carry-in", 6'h18, 32'd1, 32'd1, 1'b0, 13'h0, 32'd3, 4'b0000);
        // R6: borrow
        step("R6 subcc borrow", 6'h14, 32'd0, 32'd1, 1'b0, 13'h0, 32'hFFFFFFFF, 4'b1001);
        // R8: non-flag add leaves flags alone
        step("R8 add holds", 6'h00, 32'd2, 32'd2, 1'b0, 13'h0, 32'd4, 4'b1001);
        // R2: borrow-in subtracted
        step("R2 subxcc borrow-in", 6'h1C, 32'd5, 32'd2, 1'b0, 13'h0, 32'd2, 4'b0000);
        // R6: subtract overflow
        step("R6 subcc overflow", 6'h14, 32'h80000000, 32'd1, 1'b0, 13'h0, 32'h7FFFFFFF, 4'b0010);
        // R6 set V and C, then R7 logic clears them
        step("R6 addcc V and C", 6'h10, 32'hFFFFFFFF, 32'h80000000, 1'b0, 13'h0, 32'h7FFFFFFF, 4'b0011);
        step("R7 andcc clears", 6'h11, 32'h80000000, 32'hFFFFFFFF, 1'b0, 13'h0, 32'h80000000, 4'b1000);
        step("R7 xnorcc imm", 6'h17, 32'd0, 32'd0, 1'b1, 13'h1FFF, 32'h00000000, 4'b0100);
        // R8: unknown code gives zero, flags hold
        step("R8 unknown holds", 6'h2A, 32'd9, 32'd9, 1'b0, 13'h0, 32'h0, 4'b0100);

        // R9: mid-run reset
        step("R6 addcc set", 6'h10, 32'hFFFFFFFF, 32'd2, 1'b0, 13'h0, 32'd1, 4'b0001);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk32("R9 reset mid-run", {28'd0, icc_o}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule